// File: doc/BRIEF.md
# Delayed Transaction Retry Tracker

This block sits on the target side of a parallel bus and turns slow reads and non-posted writes into split, retried accesses. When an attempt arrives that matches nothing already held, the tracker records its command, address, byte enables and write data in a free slot. It answers the attempt with a retry and hands the recorded access to a back-end port so the real work proceeds in the background. Later attempts are compared field by field against every held slot. An exact match whose back-end access has finished receives the buffered read data and frees the slot. An exact match that is still in progress is retried again. With every slot occupied, an unmatched attempt is retried and not recorded.

Each slot carries an age counter that restarts on allocation and on every matching attempt, so an initiator that never comes back does not hold a slot for ever. The bus pin drivers and the memory behind the back-end port are outside the block. The block sees one-cycle attempt pulses and issues simple valid/ready requests with tagged completions.

Top module: `dtx_tracker`

## Requirements
- R1: After reset no slot is held. `rsp_valid`, `rsp_retry`, `rsp_done` and `be_req_valid` are low until an attempt arrives.
- R2: Every attempt (`req_valid` high at a clock edge) gets exactly one of `rsp_retry` or `rsp_done` in the next cycle, together with `rsp_valid`. Without an attempt all three stay low and `rsp_rdata` is zero.
- R3: An unmatched attempt that finds a free slot is stored in the lowest-numbered free slot and retried. From the next cycle the back-end port offers the lowest-numbered stored slot not yet accepted, with its slot number and fields. It offers each slot only once, and the slot is accepted at an edge where `be_req_ready` is high.
- R4: A slot matches only if the command, address and byte enables are all equal. For a write, the write data must also be equal; a command is a write when `req_cmd[0]` is 1. For reads the write data is ignored.
- R5: A matching attempt that arrives before the slot's completion has been received is retried again. The slot is kept and its age counter restarts.
- R6: A matching attempt that arrives after the completion (`be_cpl_valid` with `be_cpl_id` naming the slot) returns `rsp_done` with the completion data on `rsp_rdata`. The slot becomes free.
- R7: An unmatched attempt that finds no free slot is retried and is not recorded. No back-end request follows from it.
- R8: A slot whose age counter has seen no matching attempt for 2^TW clock edges is discarded. This happens only when its back-end access is not in flight, and a later identical attempt is then treated as new.
- R9: Reset discards every slot, including completed ones that were never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse: a bus attempt is presented |
| req_cmd | input | 4 | Attempt command; bit 0 set means write |
| req_addr | input | AW | Attempt address |
| req_be | input | DW/8 | Attempt byte enables |
| req_wdata | input | DW | Attempt write data |
| rsp_valid | output | 1 | Response to the attempt of the previous cycle |
| rsp_retry | output | 1 | Attempt is to be repeated later |
| rsp_done | output | 1 | Attempt completed with buffered result |
| rsp_rdata | output | DW | Buffered read data when `rsp_done` |
| be_req_valid | output | 1 | A stored access awaits the back end |
| be_req_id | output | IW | Slot number of the offered access |
| be_req_cmd | output | 4 | Offered command |
| be_req_addr | output | AW | Offered address |
| be_req_be | output | DW/8 | Offered byte enables |
| be_req_wdata | output | DW | Offered write data |
| be_req_ready | input | 1 | Back end accepts the offered access |
| be_cpl_valid | input | 1 | Back end completes an access |
| be_cpl_id | input | IW | Slot number of the completed access |
| be_cpl_rdata | input | DW | Result data of the completed access |

## Verification
The checker assumes that the back end completes only accesses it has accepted, once each, and never after a reset for an access accepted before it. It also assumes that no completion arrives for a slot still waiting to be offered. Under these conditions the count of accesses in flight never exceeds the slot count, and a delivered result always follows some completion. The bench's back end queues each accepted access and answers it a fixed number of cycles later. It empties that queue whenever it asserts reset, so the stimulus stays within these assumptions.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int CMD_W = 4;

  function automatic logic cmd_writes(input logic [CMD_W-1:0] c);
    return c[0];
  endfunction
endpackage

// File: rtl/dtx_match.sv
module dtx_match
  import dtx_pkg::*;
#(
  parameter int NENT = 2,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [AW-1:0]    q_addr,
  input  logic [DW/8-1:0]  q_be,
  input  logic [DW-1:0]    q_wdata,
  input  logic [NENT-1:0]  ent_vld,
  input  logic [CMD_W-1:0] ent_cmd   [NENT],
  input  logic [AW-1:0]    ent_addr  [NENT],
  input  logic [DW/8-1:0]  ent_be    [NENT],
  input  logic [DW-1:0]    ent_wdata [NENT],
  output logic [NENT-1:0]  hit
);
  logic wr;
  assign wr = cmd_writes(q_cmd);

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign hit[g] = ent_vld[g] && (ent_cmd[g] == q_cmd) && (ent_addr[g] == q_addr)
                    && (ent_be[g] == q_be) && (!wr || (ent_wdata[g] == q_wdata));
  end
endmodule

// File: rtl/dtx_slot.sv
module dtx_slot
  import dtx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             take,
  input  logic             touch,
  input  logic             ack,
  input  logic             cpl,
  input  logic [DW-1:0]    cpl_rdata,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW/8-1:0]  in_be,
  input  logic [DW-1:0]    in_wdata,
  output logic             vld,
  output logic             issued,
  output logic             done,
  output logic [CMD_W-1:0] cmd,
  output logic [AW-1:0]    addr,
  output logic [DW/8-1:0]  be,
  output logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam logic [TW-1:0] AGE_MAX = '1;

  logic [TW-1:0] age;
  logic          expire;

  // an access still in flight is never dropped; its completion must land first
  assign expire = vld && (age == AGE_MAX) && !touch && (done || !issued);

  always_ff @(posedge clk) begin
    if (rst || take || expire) begin
      vld    <= 1'b0;
      issued <= 1'b0;
      done   <= 1'b0;
      age    <= '0;
    end else if (alloc) begin
      vld    <= 1'b1;
      issued <= 1'b0;
      done   <= 1'b0;
      age    <= '0;
    end else if (vld) begin
      if (ack) issued <= 1'b1;
      if (cpl && issued) done <= 1'b1;
      if (touch) age <= '0;
      else if (age != AGE_MAX) age <= age + 1'b1;
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (alloc) begin
      cmd   <= in_cmd;
      addr  <= in_addr;
      be    <= in_be;
      wdata <= in_wdata;
    end
    if (cpl && issued) rdata <= cpl_rdata;
  end
endmodule

// File: rtl/dtx_tracker.sv
module dtx_tracker
  import dtx_pkg::*;
#(
  parameter int NENT = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TW   = 15,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW/8-1:0]  req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_retry,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic             be_req_valid,
  output logic [IW-1:0]    be_req_id,
  output logic [CMD_W-1:0] be_req_cmd,
  output logic [AW-1:0]    be_req_addr,
  output logic [DW/8-1:0]  be_req_be,
  output logic [DW-1:0]    be_req_wdata,
  input  logic             be_req_ready,
  input  logic             be_cpl_valid,
  input  logic [IW-1:0]    be_cpl_id,
  input  logic [DW-1:0]    be_cpl_rdata
);
  logic [NENT-1:0]  ent_vld, ent_iss, ent_done, hit, alloc_oh, sel_oh;
  logic [CMD_W-1:0] ent_cmd   [NENT];
  logic [AW-1:0]    ent_addr  [NENT];
  logic [DW/8-1:0]  ent_be    [NENT];
  logic [DW-1:0]    ent_wdata [NENT];
  logic [DW-1:0]    ent_rdata [NENT];
  logic             any_hit, hit_done, free_found, pend_found;
  logic [DW-1:0]    hit_rdata;

  dtx_match #(.NENT(NENT), .AW(AW), .DW(DW)) u_match (
    .q_cmd(req_cmd), .q_addr(req_addr), .q_be(req_be), .q_wdata(req_wdata),
    .ent_vld(ent_vld), .ent_cmd(ent_cmd), .ent_addr(ent_addr),
    .ent_be(ent_be), .ent_wdata(ent_wdata), .hit(hit)
  );

  assign any_hit = |hit;

  // lowest free slot for recording, lowest stored-but-unoffered slot for issue
  always_comb begin
    alloc_oh   = '0;
    sel_oh     = '0;
    free_found = 1'b0;
    pend_found = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (!ent_vld[i] && !free_found) begin
        alloc_oh[i] = 1'b1;
        free_found  = 1'b1;
      end
      if (ent_vld[i] && !ent_iss[i] && !pend_found) begin
        sel_oh[i]  = 1'b1;
        pend_found = 1'b1;
      end
    end
  end

  always_comb begin
    hit_done     = 1'b0;
    hit_rdata    = '0;
    be_req_id    = '0;
    be_req_cmd   = '0;
    be_req_addr  = '0;
    be_req_be    = '0;
    be_req_wdata = '0;
    for (int i = 0; i < NENT; i++) begin
      if (hit[i] && ent_done[i]) begin
        hit_done  = 1'b1;
        hit_rdata = hit_rdata | ent_rdata[i];
      end
      if (sel_oh[i]) begin
        be_req_id    = IW'(i);
        be_req_cmd   = ent_cmd[i];
        be_req_addr  = ent_addr[i];
        be_req_be    = ent_be[i];
        be_req_wdata = ent_wdata[i];
      end
    end
  end

  assign be_req_valid = pend_found;

  for (genvar g = 0; g < NENT; g++) begin : g_slot
    dtx_slot #(.AW(AW), .DW(DW), .TW(TW)) u_slot (
      .clk(clk), .rst(rst),
      .alloc(req_valid && !any_hit && alloc_oh[g]),
      .take(req_valid && hit[g] && ent_done[g]),
      .touch(req_valid && hit[g]),
      .ack(sel_oh[g] && be_req_ready),
      .cpl(be_cpl_valid && (be_cpl_id == IW'(g))),
      .cpl_rdata(be_cpl_rdata),
      .in_cmd(req_cmd), .in_addr(req_addr), .in_be(req_be), .in_wdata(req_wdata),
      .vld(ent_vld[g]), .issued(ent_iss[g]), .done(ent_done[g]),
      .cmd(ent_cmd[g]), .addr(ent_addr[g]), .be(ent_be[g]),
      .wdata(ent_wdata[g]), .rdata(ent_rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_retry <= req_valid && !hit_done;
      rsp_done  <= req_valid && hit_done;
      rsp_rdata <= (req_valid && hit_done) ? hit_rdata : '0;
    end
  end
endmodule

// File: rtl/dtx_tracker_chk.sv
module dtx_tracker_chk #(
  parameter int NENT = 2
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic rsp_valid,
  input logic rsp_retry,
  input logic rsp_done,
  input logic be_req_valid,
  input logic be_req_ready,
  input logic be_cpl_valid
);
  int   inflight;
  logic cpl_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 0;
      cpl_seen <= 1'b0;
    end else begin
      if (be_cpl_valid) cpl_seen <= 1'b1;
      if ((be_req_valid && be_req_ready) && !be_cpl_valid) inflight <= inflight + 1;
      else if (!(be_req_valid && be_req_ready) && be_cpl_valid && inflight > 0)
        inflight <= inflight - 1;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_retry && !rsp_done));
  assert_rsp_kind_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_retry ^ rsp_done));
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!be_req_valid && !rsp_valid));
  assert_inflight_bound_R3: assert property (@(posedge clk) disable iff (rst)
    inflight <= NENT);
  assert_done_after_cpl_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> cpl_seen);
endmodule

bind dtx_tracker dtx_tracker_chk #(.NENT(NENT)) u_chk (.*);

// File: tb/dtx_tracker_test.sv
module dtx_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 2, AW = 32, DW = 32, TW = 15, IW = 1, BW = DW/8, LAT = 4;
  localparam int AGE_MAX = (1 << TW) - 1;
  localparam logic [3:0] RD = 4'h6, WR = 4'h7;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, req_valid, rsp_valid, rsp_retry, rsp_done;
  logic [3:0] req_cmd, be_req_cmd;
  logic [AW-1:0] req_addr, be_req_addr;
  logic [BW-1:0] req_be, be_req_be;
  logic [DW-1:0] req_wdata, rsp_rdata, be_req_wdata, be_cpl_rdata;
  logic be_req_valid, be_req_ready, be_cpl_valid;
  logic [IW-1:0] be_req_id, be_cpl_id;

  dtx_tracker #(.NENT(NENT), .AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .be_req_valid(be_req_valid), .be_req_id(be_req_id),
    .be_req_cmd(be_req_cmd), .be_req_addr(be_req_addr), .be_req_be(be_req_be),
    .be_req_wdata(be_req_wdata), .be_req_ready(be_req_ready),
    .be_cpl_valid(be_cpl_valid), .be_cpl_id(be_cpl_id), .be_cpl_rdata(be_cpl_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model
  bit            m_vld [NENT];
  bit            m_iss [NENT];
  bit            m_done[NENT];
  logic [3:0]    m_cmd [NENT];
  logic [AW-1:0] m_addr[NENT];
  logic [BW-1:0] m_be  [NENT];
  logic [DW-1:0] m_wd  [NENT];
  logic [DW-1:0] m_rd  [NENT];
  int            m_age [NENT];
  bit e_rv, e_rr, e_rd;
  logic [DW-1:0] e_rdat;
  string e_tag = "R1";

  typedef struct { int id; logic [DW-1:0] d; int due; } cpl_t;
  cpl_t bq[$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    int h, s, f;
    bit touch, was_iss;
    if (rst) begin
      for (int i = 0; i < NENT; i++) begin
        m_vld[i] = 0; m_iss[i] = 0; m_done[i] = 0; m_age[i] = 0;
      end
      e_rv = 0; e_rr = 0; e_rd = 0; e_rdat = '0; e_tag = "R9";
      return;
    end
    h = -1; s = -1; f = -1;
    for (int i = NENT-1; i >= 0; i--) begin
      if (m_vld[i] && m_cmd[i] == req_cmd && m_addr[i] == req_addr && m_be[i] == req_be
          && (!req_cmd[0] || m_wd[i] == req_wdata)) h = i;
      if (m_vld[i] && !m_iss[i]) s = i;
      if (!m_vld[i]) f = i;
    end
    e_rv = req_valid; e_rr = 0; e_rd = 0; e_rdat = '0; e_tag = "R2";
    if (req_valid) begin
      if (h >= 0 && m_done[h]) begin e_rd = 1; e_rdat = m_rd[h]; e_tag = "R6"; end
      else begin
        e_rr = 1;
        e_tag = (h >= 0) ? "R5" : ((f >= 0) ? "R3" : "R7");
      end
    end
    for (int i = 0; i < NENT; i++) begin
      touch = req_valid && (h == i);
      was_iss = m_iss[i];
      if (m_vld[i] && touch && m_done[i]) begin
        m_vld[i] = 0; m_iss[i] = 0; m_done[i] = 0;
      end else if (m_vld[i] && !touch && m_age[i] == AGE_MAX && (m_done[i] || !m_iss[i])) begin
        m_vld[i] = 0; m_iss[i] = 0; m_done[i] = 0;
      end else if (!m_vld[i] && req_valid && h < 0 && f == i) begin
        m_vld[i] = 1; m_iss[i] = 0; m_done[i] = 0; m_age[i] = 0;
        m_cmd[i] = req_cmd; m_addr[i] = req_addr; m_be[i] = req_be; m_wd[i] = req_wdata;
      end else if (m_vld[i]) begin
        if (s == i && be_req_ready) m_iss[i] = 1;
        if (be_cpl_valid && be_cpl_id == IW'(i) && was_iss) begin
          m_done[i] = 1; m_rd[i] = be_cpl_rdata;
        end
        if (touch) m_age[i] = 0;
        else if (m_age[i] < AGE_MAX) m_age[i]++;
      end
    end
  endtask

  task automatic compare();
    int s;
    bit ok;
    check(rsp_valid === e_rv && rsp_retry === e_rr && rsp_done === e_rd && rsp_rdata === e_rdat,
          e_tag, {rsp_valid, rsp_retry, rsp_done, rsp_rdata}, {e_rv, e_rr, e_rd, e_rdat});
    s = -1;
    for (int i = NENT-1; i >= 0; i--) if (m_vld[i] && !m_iss[i]) s = i;
    if (s < 0) ok = (be_req_valid === 1'b0);
    else ok = be_req_valid === 1'b1 && be_req_id === IW'(s) && be_req_cmd === m_cmd[s]
              && be_req_addr === m_addr[s] && be_req_be === m_be[s] && be_req_wdata === m_wd[s];
    check(ok, "R3", {be_req_valid, be_req_id, be_req_addr},
          (s < 0) ? 64'd0 : {1'b1, IW'(s), m_addr[s]});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    compare();
    if (bq.size() > 0 && bq[0].due <= cyc) begin
      be_cpl_valid = 1; be_cpl_id = IW'(bq[0].id); be_cpl_rdata = bq[0].d;
      void'(bq.pop_front());
    end else begin
      be_cpl_valid = 0; be_cpl_id = '0; be_cpl_rdata = '0;
    end
    be_req_ready = (cyc % 3 != 1);
    #1;
    if (be_req_valid && be_req_ready && !rst)
      bq.push_back('{int'(be_req_id), be_req_addr ^ 32'hC3C3_0000, cyc + LAT});
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic attempt(logic [3:0] c, logic [AW-1:0] a, logic [BW-1:0] b, logic [DW-1:0] w);
    req_valid = 1; req_cmd = c; req_addr = a; req_be = b; req_wdata = w;
    tick();
    req_valid = 0;
  endtask

  task automatic do_reset(int n);
    rst = 1;
    repeat (n) begin tick(); bq.delete(); end
    rst = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_cmd = '0; req_addr = '0; req_be = '0; req_wdata = '0;
    be_req_ready = 0; be_cpl_valid = 0; be_cpl_id = '0; be_cpl_rdata = '0;
    do_reset(3);
    check(rsp_valid === 0 && be_req_valid === 0, "R1", {rsp_valid, be_req_valid}, 0);

    // record, early repeat, delivery, re-record after free
    attempt(RD, 32'h100, 4'hF, 32'h0);
    check(rsp_retry === 1, "R3", rsp_retry, 1);
    idle(1);
    attempt(RD, 32'h100, 4'hF, 32'h0);
    check(rsp_retry === 1, "R5", rsp_retry, 1);
    idle(10);
    attempt(RD, 32'h100, 4'hF, 32'h0);
    check(rsp_done === 1 && rsp_rdata === (32'h100 ^ 32'hC3C3_0000), "R6",
          {rsp_done, rsp_rdata}, {1'b1, 32'h100 ^ 32'hC3C3_0000});
    attempt(RD, 32'h100, 4'hF, 32'hDEAD);
    check(rsp_retry === 1, "R6", rsp_retry, 1);
    idle(10);
    attempt(RD, 32'h100, 4'hF, 32'hBEEF);
    check(rsp_done === 1, "R4", rsp_done, 1);

    // fill both slots, then overflow
    attempt(WR, 32'h200, 4'hF, 32'h11);
    attempt(RD, 32'h300, 4'h3, 32'h0);
    attempt(WR, 32'h200, 4'hF, 32'h22);
    check(rsp_retry === 1, "R7", rsp_retry, 1);
    idle(10);
    attempt(WR, 32'h200, 4'hF, 32'h22);
    check(rsp_retry === 1, "R4", rsp_retry, 1);
    attempt(RD, 32'h300, 4'h1, 32'h0);
    check(rsp_retry === 1, "R7", rsp_retry, 1);
    attempt(WR, 32'h200, 4'hF, 32'h11);
    check(rsp_done === 1, "R6", rsp_done, 1);
    attempt(WR, 32'h200, 4'hF, 32'h22);
    attempt(RD, 32'h300, 4'h3, 32'h0);
    check(rsp_done === 1, "R6", rsp_done, 1);
    idle(10);
    attempt(WR, 32'h200, 4'hF, 32'h22);
    check(rsp_done === 1, "R4", rsp_done, 1);

    // mixed pattern, compared against the model every cycle
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 2) idle(1);
      else begin
        case ((i * 7 + i / 5) % 5)
          0: attempt(RD, 32'h100, 4'hF, 32'(i));
          1: attempt(WR, 32'h200, 4'hF, 32'h11);
          2: attempt(RD, 32'h300, 4'h3, 32'h0);
          3: attempt(WR, 32'h200, 4'hF, 32'h22);
          default: attempt(RD, 32'h300, 4'h1, 32'h0);
        endcase
      end
    end
    idle(20);

    // reset drops a completed, undelivered slot
    do_reset(2);
    attempt(RD, 32'h400, 4'hF, 32'h0);
    idle(10);
    do_reset(2);
    attempt(RD, 32'h400, 4'hF, 32'h0);
    check(rsp_retry === 1, "R9", rsp_retry, 1);

    // age limit: kept well inside, dropped well past
    idle(32000);
    attempt(RD, 32'h400, 4'hF, 32'h0);
    check(rsp_done === 1, "R8", rsp_done, 1);
    attempt(RD, 32'h400, 4'hF, 32'h0);
    idle(33000);
    attempt(RD, 32'h400, 4'hF, 32'h0);
    check(rsp_retry === 1, "R8", rsp_retry, 1);
    idle(10);

    summary();
    $finish;
  end
endmodule